// File: doc/BRIEF.md
# GPIO Interrupt Cause and Mask Unit

This block is the interrupt front end for a bank of 32 general-purpose input lines. Each pin is brought into the clock domain through a two-stage synchroniser. It is then optionally inverted by its own polarity bit, which produces the "sensed" view that software can read back. That view feeds two cause paths:

- A **level path** uses the sensed bit directly.
- An **edge path** records every low-to-high step of the sensed bit in a sticky register.

Separate mask registers gate each path. The gated causes of each eight-line group are ORed into one of four summary interrupt lines for a downstream interrupt controller.

Software reaches the registers through a plain word-wide port: a byte offset, a write strobe, write data, and combinational read data. A per-line enable input, driven by the pin-direction logic outside the block, removes lines that are not configured as inputs from interrupt detection. Because one polarity bit sets both the level sense and the edge direction, the same line can be switched between active-high/rising and active-low/falling detection. Flipping the polarity bit after each event gives detection on both edges.

The block has no sequencing state machine. Its state consists of the synchroniser, the previous-sample register, the edge latch and the three software registers.

Top module: `gpio_irq_front`

## Requirements
- R1: The sensed register at byte offset 0x110 reads as the synchronised pin XOR the polarity register. A pin change appears there after exactly two rising clock edges. Writes to 0x110 have no effect.
- R2: A line's level cause is its sensed bit AND its level-mask bit (offset 0x11C) AND its enable input.
- R3: An edge-cause bit (offset 0x114) is set only when the sensed bit of an enabled line was 0 at one clock sample and 1 at the next. The bit becomes visible one edge after the sensed bit rises, which is three edges after the pin change.
- R4: Summary output bit g is the OR, over lines 8g to 8g+7, of (level cause) OR (edge-cause bit AND edge-mask bit at offset 0x118).
- R5: Edge-cause bits are sticky. A write to 0x114 clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R6: When an edge sets a bit in the same cycle that a write clears it, the bit ends up set.
- R7: With polarity bit 0 (offset 0x10C) the line detects high levels and rising pin edges. With polarity bit 1 it detects low levels and falling pin edges.
- R8: A line whose enable input is 0 produces neither a level cause nor an edge-cause bit.
- R9: After reset, the polarity, edge-cause, edge-mask and level-mask registers read zero and all four summary outputs are low.
- R10: Reading any offset other than the five listed returns zero. Writing such an offset changes no register.
- R11: The polarity, edge-mask and level-mask registers read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Raw, asynchronous GPIO pin levels |
| line_en_i | input | 32 | Per-line interrupt enable (1 = line is an input) |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wr_i | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| irq_grp_o | output | 4 | Summary interrupt, one per eight-line group |

## Verification
The hardest case to reach from the ports is a clearing write that lands in exactly the cycle when a new edge is latched into the same bit.

The bench reaches it by counting the synchroniser and previous-sample stages. It changes the pin on a falling clock edge and holds the write strobe for the third rising edge after that change. It then reads the edge-cause register to confirm that the bit survived.

Falling-edge detection is set up in a similar way. The pin is raised first, the polarity is flipped, and the stray cause this produces is cleared before the pin is dropped.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int ADDR_W = 12;
    localparam logic [ADDR_W-1:0] OFS_POLARITY   = 12'h10C;
    localparam logic [ADDR_W-1:0] OFS_SENSED     = 12'h110;
    localparam logic [ADDR_W-1:0] OFS_EDGE_CAUSE = 12'h114;
    localparam logic [ADDR_W-1:0] OFS_EDGE_MASK  = 12'h118;
    localparam logic [ADDR_W-1:0] OFS_LEVEL_MASK = 12'h11C;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_latch.sv
module gpio_edge_latch #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sensed_i,
    input  logic [WIDTH-1:0] line_en_i,
    input  logic             clr_we_i,
    input  logic [WIDTH-1:0] keep_i,
    output logic [WIDTH-1:0] cause_o
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] cause_q;
    logic [WIDTH-1:0] set_vec;
    logic [WIDTH-1:0] after_clr;

    assign set_vec   = sensed_i & ~prev_q & line_en_i;
    assign after_clr = clr_we_i ? (cause_q & keep_i) : cause_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            cause_q <= '0;
        end else begin
            prev_q  <= sensed_i;
            cause_q <= after_clr | set_vec;
        end
    end

    assign cause_o = cause_q;

    // R3: a cause bit rises only where the sensed input rose on an enabled line
    p_no_spurious_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1 |=> ((cause_q & ~$past(cause_q)) & ~($past(sensed_i) & ~$past(prev_q))) == '0);
    // R8: disabled lines never gain a cause bit
    p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1 |=> ((cause_q & ~$past(cause_q)) & ~$past(line_en_i)) == '0);
    // R5: set bits not written as zero stay set
    p_sticky_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1 |=> (($past(cause_q) & ~($past(clr_we_i) ? ~$past(keep_i) : '0)) & ~cause_q) == '0);
    // R6: a detected edge always lands, even against a clearing write
    p_edge_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((cause_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/gpio_group_or.sv
module gpio_group_or #(
    parameter int WIDTH       = 32,
    parameter int GROUP_LINES = 8,
    localparam int NUM_GROUPS = WIDTH / GROUP_LINES
) (
    input  logic [WIDTH-1:0]      level_cause_i,
    input  logic [WIDTH-1:0]      edge_cause_i,
    output logic [NUM_GROUPS-1:0] irq_o
);
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign irq_o[g] = |(level_cause_i[g*GROUP_LINES +: GROUP_LINES]
                          | edge_cause_i[g*GROUP_LINES +: GROUP_LINES]);
    end
endmodule

// File: rtl/gpio_irq_front.sv
module gpio_irq_front
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES   = 32,
    parameter int GROUP_LINES = 8,
    localparam int NUM_GROUPS = NUM_LINES / GROUP_LINES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  pin_i,
    input  logic [NUM_LINES-1:0]  line_en_i,
    input  logic [ADDR_W-1:0]     reg_addr_i,
    input  logic                  reg_wr_i,
    input  logic [NUM_LINES-1:0]  reg_wdata_i,
    output logic [NUM_LINES-1:0]  reg_rdata_o,
    output logic [NUM_GROUPS-1:0] irq_grp_o
);
    logic [NUM_LINES-1:0] pin_sync;
    logic [NUM_LINES-1:0] sensed;
    logic [NUM_LINES-1:0] pol_q, emask_q, lmask_q;
    logic [NUM_LINES-1:0] edge_cause;
    logic [NUM_LINES-1:0] level_cause;
    logic                 cause_we;

    gpio_in_sync #(.WIDTH(NUM_LINES), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    assign sensed   = pin_sync ^ pol_q;
    assign cause_we = reg_wr_i && (reg_addr_i == OFS_EDGE_CAUSE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q   <= '0;
            emask_q <= '0;
            lmask_q <= '0;
        end else if (reg_wr_i) begin
            if (reg_addr_i == OFS_POLARITY)   pol_q   <= reg_wdata_i;
            if (reg_addr_i == OFS_EDGE_MASK)  emask_q <= reg_wdata_i;
            if (reg_addr_i == OFS_LEVEL_MASK) lmask_q <= reg_wdata_i;
        end
    end

    gpio_edge_latch #(.WIDTH(NUM_LINES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sensed_i  (sensed),
        .line_en_i (line_en_i),
        .clr_we_i  (cause_we),
        .keep_i    (reg_wdata_i),
        .cause_o   (edge_cause)
    );

    assign level_cause = sensed & lmask_q & line_en_i;

    gpio_group_or #(.WIDTH(NUM_LINES), .GROUP_LINES(GROUP_LINES)) u_grp (
        .level_cause_i (level_cause),
        .edge_cause_i  (edge_cause & emask_q),
        .irq_o         (irq_grp_o)
    );

    always_comb begin
        unique case (reg_addr_i)
            OFS_POLARITY:   reg_rdata_o = pol_q;
            OFS_SENSED:     reg_rdata_o = sensed;
            OFS_EDGE_CAUSE: reg_rdata_o = edge_cause;
            OFS_EDGE_MASK:  reg_rdata_o = emask_q;
            OFS_LEVEL_MASK: reg_rdata_o = lmask_q;
            default:        reg_rdata_o = '0;
        endcase
    end

    // R11 / R10: a mask register changes only on a write to its own offset
    p_lmask_write_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && reg_addr_i == OFS_LEVEL_MASK) |=> $stable(lmask_q));
    // R9: with both masks clear no summary output can be high
    p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lmask_q == '0 && emask_q == '0) |-> irq_grp_o == '0);
endmodule

// File: tb/gpio_irq_front_test.sv
`timescale 1ns/1ps
module gpio_irq_front_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin = '0;
    logic [31:0] en = '1;
    logic [11:0] addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    localparam logic [11:0] A_POL = 12'h10C, A_SEN = 12'h110, A_CAU = 12'h114,
                            A_EMK = 12'h118, A_LMK = 12'h11C;

    gpio_irq_front uut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .line_en_i(en),
        .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_grp_o(irq)
    );

    always #2.5 clk = ~clk;

    // fields: pins, polarity, level mask, enable, expected sensed, expected irq
    localparam int NV = 8;
    localparam logic [163:0] VEC [NV] = '{
        {32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 4'b0000},
        {32'h0000_0001, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0001, 4'b0001},
        {32'h0000_0100, 32'h0000_0000, 32'h0000_00FF, 32'hFFFF_FFFF, 32'h0000_0100, 4'b0000},
        {32'h0000_0000, 32'hFF00_0000, 32'hFF00_0000, 32'hFFFF_FFFF, 32'hFF00_0000, 4'b1000},
        {32'h00FF_0000, 32'h00FF_0000, 32'h00FF_0000, 32'hFFFF_FFFF, 32'h0000_0000, 4'b0000},
        {32'h1234_5678, 32'h0000_0000, 32'h0004_0000, 32'hFFFF_FFFF, 32'h1234_5678, 4'b0100},
        {32'h8000_0000, 32'h0000_0000, 32'h8000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 4'b0000},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 4'b0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rreg(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #0.5 d = rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        rreg(A_POL, v); check("R9 pol", v, 0);
        rreg(A_CAU, v); check("R9 cause", v, 0);
        rreg(A_EMK, v); check("R9 emask", v, 0);
        rreg(A_LMK, v); check("R9 lmask", v, 0);
        check("R9 irq", {28'd0, irq}, 0);

        // R1 R2 R4 R7 R8: level vectors
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            en  = VEC[i][67:36];
            pin = VEC[i][163:132];
            wreg(A_POL, VEC[i][131:100]);
            wreg(A_LMK, VEC[i][99:68]);
            settle();
            rreg(A_SEN, v); check($sformatf("R1 sensed vec%0d", i), v, VEC[i][35:4]);
            check($sformatf("R2 R4 irq vec%0d", i), {28'd0, irq}, {28'd0, VEC[i][3:0]});
        end

        // clean start for edge tests
        @(negedge clk); pin = '0; en = '1;
        wreg(A_POL, 0); wreg(A_LMK, 0); settle(); wreg(A_CAU, 0);

        // R3 R4 rising edge
        wreg(A_EMK, 32'h8);
        @(negedge clk); pin[3] = 1'b1; settle();
        rreg(A_CAU, v); check("R3 rise cause", v, 32'h8);
        check("R4 edge irq", {28'd0, irq}, 32'h1);
        // R5 sticky after pin returns
        @(negedge clk); pin[3] = 1'b0; settle();
        rreg(A_CAU, v); check("R5 sticky", v, 32'h8);
        // R5 write-zero clears only that bit
        @(negedge clk); pin[5] = 1'b1; settle();
        rreg(A_CAU, v); check("R3 second edge", v, 32'h28);
        wreg(A_CAU, 32'hFFFF_FFF7);
        rreg(A_CAU, v); check("R5 selective clear", v, 32'h20);
        check("R4 edge mask gates", {28'd0, irq}, 0);
        @(negedge clk); pin[5] = 1'b0; settle(); wreg(A_CAU, 0);

        // R7 falling edge
        @(negedge clk); pin[9] = 1'b1; settle();
        wreg(A_POL, 32'h200); settle(); wreg(A_CAU, 0);
        wreg(A_EMK, 32'h200);
        check("R7 no fall yet", {28'd0, irq}, 0);
        @(negedge clk); pin[9] = 1'b0; settle();
        rreg(A_CAU, v); check("R7 fall cause", v, 32'h200);
        check("R7 fall irq", {28'd0, irq}, 32'h2);
        wreg(A_POL, 0); settle(); wreg(A_CAU, 0);

        // R8 disabled line
        @(negedge clk); en = ~32'h1000;
        wreg(A_LMK, 32'h1000); wreg(A_EMK, 32'h1000);
        @(negedge clk); pin[12] = 1'b1; settle();
        rreg(A_CAU, v); check("R8 no edge cause", v, 0);
        check("R8 no irq", {28'd0, irq}, 0);
        @(negedge clk); pin[12] = 1'b0; settle(); en = '1;
        wreg(A_LMK, 0); wreg(A_EMK, 0); wreg(A_CAU, 0);

        // R6 collision: write lands on third edge after pin change
        @(negedge clk); pin[3] = 1'b1;
        @(negedge clk);
        @(negedge clk); addr = A_CAU; wdata = 32'hFFFF_FFF7; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        rreg(A_CAU, v); check("R6 edge wins", v, 32'h8);
        @(negedge clk); pin[3] = 1'b0; settle(); wreg(A_CAU, 0);

        // R1 latency and read-only
        @(negedge clk); addr = A_SEN; pin[0] = 1'b1;
        @(negedge clk); #0.5 check("R1 one edge", rdata, 0);
        @(negedge clk); #0.5 check("R1 two edges", rdata, 32'h1);
        wreg(A_SEN, 32'hFFFF_FFFF);
        rreg(A_SEN, v); check("R1 read-only", v, 32'h1);

        // R11 readback
        wreg(A_LMK, 32'hA5A5_A5A5); rreg(A_LMK, v); check("R11 lmask", v, 32'hA5A5_A5A5);
        wreg(A_EMK, 32'h5A5A_5A5A); rreg(A_EMK, v); check("R11 emask", v, 32'h5A5A_5A5A);
        wreg(A_POL, 32'h0F0F_0F0F); rreg(A_POL, v); check("R11 pol", v, 32'h0F0F_0F0F);
        rreg(A_SEN, v); check("R1 inverted", v, 32'h0F0F_0F0E);

        // R10 unmapped offsets
        rreg(12'h120, v); check("R10 read zero", v, 0);
        wreg(12'h100, 32'hFFFF_FFFF);
        rreg(A_LMK, v); check("R10 lmask kept", v, 32'hA5A5_A5A5);
        rreg(A_EMK, v); check("R10 emask kept", v, 32'h5A5A_5A5A);
        rreg(A_POL, v); check("R10 pol kept", v, 32'h0F0F_0F0F);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule